// File: doc/BRIEF.md
# Two-wire serial EEPROM slave

This block behaves as the device end of a two-wire serial EEPROM. The wire levels SCL and SDA come in as plain logic bits. They are resynchronised and sampled on the system clock. The block returns the bit that the device would put on SDA. A start condition arms a bit-cycle counter. Each SCL rising edge advances that counter. Each SCL falling edge latches one bit from SDA. The counter value decides whether that bit belongs to a device-select byte, a word-address byte or a data byte. Data bytes are shifted into an internal byte array, and reads stream bytes from that array onto the output.

A two-bit variant input selects one of three command formats. The first is a legacy single-byte format, in which one byte carries a 7-bit word address and the direction bit. The second uses a device-select byte followed by one address byte, with the select byte supplying address bits 10:8. The third uses a device-select byte followed by two address bytes. Writes wrap inside a page. Sequential reads walk through the whole array.

A side port loads bytes straight into the array, so that a test or a boot sequence can give the array known contents. This port is a valid/ready stream. `pl_ready` is held high at all times, so the port never applies back-pressure. Every clock edge with `pl_valid` high stores `pl_data` at `pl_addr`, and the byte is readable over the bus from the next cycle on.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset, and at any time no start is in effect, `sda_out` equals the sampled SDA level.
- R2: A start condition is SDA falling while SCL stays high. It zeroes the bit counter and leaves the address register alone, so that a read begun straight after a start continues from the address the previous transfer left. A stop condition is SDA rising while SCL stays high, and it disarms the block.
- R3: While armed, `sda_out` is 0 whenever the bit counter is at 9, 18 or 27 (the acknowledge slots), whatever SDA carries.
- R4: In legacy variant (`mode`=0), the first byte holds the word address in bits 7:1 and the direction in bit 0, where 0 means write. Write data bytes go MSB first into the addressed byte. After each byte, only word-address bits 1:0 advance, so a page of four bytes wraps.
- R5: In a legacy read, the byte at the word address is driven MSB first during counter values 10 to 17, and the word address then advances by one modulo 128.
- R6: In the one-address-byte variant (`mode`=1), the byte after the device select gives address bits 7:0. Select-byte bits 3:1 become address bits 10:8, and select-byte bit 0 is the direction.
- R7: In the two-address-byte variant (`mode`=2 or 3), two address bytes follow the select byte, high byte first. The address register keeps their low MEM_AW bits.
- R8: In the extended variants, each completed write byte advances only address bits 3:0, so a page of sixteen bytes wraps.
- R9: An extended read streams consecutive bytes. The address increments across page borders and wraps from the top of the array to 0.
- R10: During write-data bit slots, `sda_out` equals the sampled SDA level.
- R11: With `pl_valid` high, the byte on `pl_data` is stored at `pl_addr` on that clock edge. `pl_ready` is always 1.
- R12: While no start is in effect, SCL pulses change neither the address register nor the array. Each sample is handled as at most one bus event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Variant: 0 legacy, 1 one address byte, 2/3 two address bytes |
| scl_in | input | 1 | Serial clock line level |
| sda_in | input | 1 | Serial data line level driven by the master |
| sda_out | output | 1 | Data line level the device returns |
| pl_valid | input | 1 | Preload byte valid |
| pl_ready | output | 1 | Preload accept, constant 1 |
| pl_addr | input | MEM_AW | Preload byte index |
| pl_data | input | 8 | Preload byte value |

## Verification
A wrong bit counter shows up within one SCL period. It makes an acknowledge slot return the SDA level rather than 0, or it moves read data by a bit position. A wrong address register stays hidden until the next read, where it appears as a whole wrong byte. For that reason, every write burst is followed by reads that cross page borders and the top of the array. A stray event processed while the block is disarmed is caught by a current-address read: that read must pick up exactly where the last write left the address.

// File: rtl/twe_pkg.sv
package twe_pkg;

  localparam int CYC_W = 6;
  typedef logic [CYC_W-1:0] cyc_t;

  // bit-counter landmarks of the serial protocol
  localparam cyc_t C_ACK_A   = 6'd9;
  localparam cyc_t C_ACK_B   = 6'd18;
  localparam cyc_t C_ACK_C   = 6'd27;
  localparam cyc_t C_END_B1  = 6'd17;
  localparam cyc_t C_END_B2  = 6'd26;
  localparam cyc_t C_END_B3  = 6'd35;
  localparam cyc_t C_WRAP_2A = 6'd36;

  typedef enum logic [1:0] {
    VAR_LEGACY = 2'd0,
    VAR_ADDR1  = 2'd1,
    VAR_ADDR2  = 2'd2,
    VAR_ADDR2B = 2'd3
  } variant_e;

  typedef struct packed {
    logic start;
    logic stop;
    logic rise;
    logic fall;
  } bus_ev_t;

endpackage

// File: rtl/twe_line_sampler.sv
module twe_line_sampler
  import twe_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    scl_in,
  input  logic    sda_in,
  output logic    sda_s,
  output bus_ev_t ev
);

  logic [STAGES-1:0] scl_p, sda_p;
  logic              scl_q, sda_q;
  logic              scl_c;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_p <= '1;
      sda_p <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_p[0] <= scl_in;
      sda_p[0] <= sda_in;
      for (int i = 1; i < STAGES; i++) begin
        scl_p[i] <= scl_p[i-1];
        sda_p[i] <= sda_p[i-1];
      end
      scl_q <= scl_p[STAGES-1];
      sda_q <= sda_p[STAGES-1];
    end
  end

  assign scl_c = scl_p[STAGES-1];
  assign sda_s = sda_p[STAGES-1];

  // SCL high on both samples: SDA edges are conditions; otherwise SCL edges
  always_comb begin
    ev.start = scl_q & scl_c & sda_q & ~sda_s;
    ev.stop  = scl_q & scl_c & ~sda_q & sda_s;
    ev.rise  = ~scl_q & scl_c;
    ev.fall  = scl_q & ~scl_c;
  end

endmodule

// File: rtl/twe_proto_seq.sv
module twe_proto_seq
  import twe_pkg::*;
#(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  variant_e      mode,
  input  bus_ev_t       ev,
  input  logic          sda_bit,
  output logic          started,
  output cyc_t          cyc,
  output logic [AW-1:0] addr,
  output logic          rd_mode,
  output logic [AW-1:0] mem_idx,
  output logic          wr_en
);

  logic [3:0]    dsel, dsel_n;
  logic          started_n;
  cyc_t          cyc_n, cyc_inc;
  logic [AW-1:0] addr_n;
  logic          ext, two, is_ack;

  assign ext    = (mode != VAR_LEGACY);
  assign two    = (mode == VAR_ADDR2) || (mode == VAR_ADDR2B);
  assign is_ack = (cyc == C_ACK_A) || (cyc == C_ACK_B) || (cyc == C_ACK_C);
  assign rd_mode = ext ? dsel[0] : addr[0];
  assign cyc_inc = cyc + cyc_t'(1);

  always_comb begin
    mem_idx = addr;
    if (!ext) begin
      mem_idx      = '0;
      mem_idx[6:0] = addr[7:1];
    end
  end

  always_comb begin
    started_n = started;
    cyc_n     = cyc;
    addr_n    = addr;
    dsel_n    = dsel;
    wr_en     = 1'b0;
    if (ev.start) begin
      started_n = 1'b1;
      cyc_n     = '0;
    end else if (ev.stop) begin
      started_n = 1'b0;
    end else if (started && ev.rise) begin
      cyc_n = cyc_inc;
      if (!ext) begin
        if (cyc_inc == C_ACK_B) begin
          cyc_n = C_ACK_A;
          if (addr[0]) begin
            addr_n      = '0;
            addr_n[7:0] = addr[7:0] + 8'd2;
          end
        end
      end else if (dsel[0] && cyc_inc == C_ACK_B) begin
        cyc_n  = C_ACK_A;
        addr_n = addr + AW'(1);
      end else if (!two && cyc_inc == C_ACK_C) begin
        cyc_n = C_ACK_B;
      end else if (cyc_inc == C_WRAP_2A) begin
        cyc_n = C_ACK_C;
      end
    end else if (started && ev.fall) begin
      if (!ext) begin
        if (cyc == C_ACK_A) begin
          // acknowledge slot
        end else if (cyc > C_ACK_A) begin
          if (!addr[0]) begin
            wr_en = 1'b1;
            if (cyc == C_END_B1) addr_n[2:1] = addr[2:1] + 2'd1;
          end
        end else begin
          addr_n      = '0;
          addr_n[7:0] = {addr[6:0], sda_bit};
        end
      end else begin
        if (is_ack) begin
          // acknowledge slot
        end else if ((two && cyc > C_ACK_C) || (!two && cyc > C_ACK_B)) begin
          if (!dsel[0]) begin
            wr_en = 1'b1;
            if (cyc == C_END_B2 || cyc == C_END_B3) addr_n[3:0] = addr[3:0] + 4'd1;
          end
        end else if (cyc > C_ACK_A) begin
          if (!dsel[0]) begin
            if (two) begin
              addr_n = {addr[AW-2:0], sda_bit};
            end else begin
              addr_n      = '0;
              addr_n[7:0] = {addr[6:0], sda_bit};
              if (cyc == C_END_B1) addr_n[10:8] = dsel[3:1];
            end
          end
        end else begin
          dsel_n = {dsel[2:0], sda_bit};
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      started <= 1'b0;
      cyc     <= '0;
      addr    <= '0;
      dsel    <= '0;
    end else begin
      started <= started_n;
      cyc     <= cyc_n;
      addr    <= addr_n;
      dsel    <= dsel_n;
    end
  end

endmodule

// File: rtl/twe_byte_store.sv
module twe_byte_store #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          pl_en,
  input  logic [AW-1:0] pl_idx,
  input  logic [7:0]    pl_data,
  input  logic          sh_en,
  input  logic [AW-1:0] sh_idx,
  input  logic          sh_bit,
  input  logic [AW-1:0] rd_idx,
  output logic [7:0]    rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (pl_en) mem[pl_idx] <= pl_data;
    else if (sh_en) mem[sh_idx] <= {mem[sh_idx][6:0], sh_bit};
  end

  assign rd_data = mem[rd_idx];

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
  import twe_pkg::*;
#(
  parameter int MEM_AW      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_out,
  input  logic              pl_valid,
  output logic              pl_ready,
  input  logic [MEM_AW-1:0] pl_addr,
  input  logic [7:0]        pl_data
);

  bus_ev_t           bus_ev;
  logic              sda_s;
  logic              started, rd_mode, wr_en;
  cyc_t              cyc;
  logic [MEM_AW-1:0] addr, mem_idx;
  logic [7:0]        rd_data;
  logic [2:0]        bit_sel;
  variant_e          var_sel;

  assign var_sel  = variant_e'(mode);
  assign pl_ready = 1'b1;

  twe_line_sampler #(.STAGES(SYNC_STAGES)) u_line (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_s(sda_s), .ev(bus_ev)
  );

  twe_proto_seq #(.AW(MEM_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode(var_sel), .ev(bus_ev), .sda_bit(sda_s),
    .started(started), .cyc(cyc), .addr(addr), .rd_mode(rd_mode),
    .mem_idx(mem_idx), .wr_en(wr_en)
  );

  twe_byte_store #(.AW(MEM_AW)) u_store (
    .clk(clk), .pl_en(pl_valid & pl_ready), .pl_idx(pl_addr), .pl_data(pl_data),
    .sh_en(wr_en), .sh_idx(mem_idx), .sh_bit(sda_s),
    .rd_idx(mem_idx), .rd_data(rd_data)
  );

  // counter 10 selects bit 7, counter 17 selects bit 0
  assign bit_sel = 3'd1 - cyc[2:0];

  always_comb begin
    sda_out = sda_s;
    if (started) begin
      if (cyc == C_ACK_A || cyc == C_ACK_B || cyc == C_ACK_C) sda_out = 1'b0;
      else if (cyc > C_ACK_A && cyc < C_ACK_B && rd_mode) sda_out = rd_data[bit_sel];
    end
  end

endmodule

// File: rtl/twe_chk.sv
module twe_chk
  import twe_pkg::*;
#(
  parameter int AW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input bus_ev_t       ev,
  input logic          started,
  input cyc_t          cyc,
  input logic [AW-1:0] addr,
  input logic          rd,
  input logic          sda_out
);

  a_r2_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
    ev.start |=> started && cyc == '0);

  a_r2_stop_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    ev.stop |=> !started);

  a_r12_one_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev));

  a_r12_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev.start || ev.stop || ev.rise || ev.fall) |=> $stable(cyc) && $stable(addr) && $stable(started));

  a_r12_idle_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (!started && !ev.start) |=> $stable(addr));

  a_r3_ack_low: assert property (@(posedge clk) disable iff (!rst_n)
    started && (cyc == C_ACK_A || cyc == C_ACK_B || cyc == C_ACK_C) |-> !sda_out);

  a_r4_legacy_page: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && started && ev.fall && cyc == C_END_B1 && !addr[0])
    |=> addr[7:3] == $past(addr[7:3]) && addr[2:1] == $past(addr[2:1]) + 2'd1);

  a_r8_ext_page: assert property (@(posedge clk) disable iff (!rst_n)
    (started && ev.fall && !rd &&
     ((mode == 2'd1 && cyc == C_END_B2) || (mode[1] && cyc == C_END_B3)))
    |=> addr[AW-1:4] == $past(addr[AW-1:4]) && addr[3:0] == $past(addr[3:0]) + 4'd1);

endmodule

bind serial_eeprom_slave twe_chk #(.AW(MEM_AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .ev(bus_ev), .started(started),
  .cyc(cyc), .addr(addr), .rd(rd_mode), .sda_out(sda_out)
);

// File: tb/sim_serial_eeprom_slave.sv
module sim_serial_eeprom_slave;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int AW    = 11;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          scl = 1'b1, sda = 1'b1;
  logic          sda_out, pl_ready;
  logic          pl_valid = 1'b0;
  logic [AW-1:0] pl_addr = '0;
  logic [7:0]    pl_data = '0;

  always #2 clk = ~clk;

  serial_eeprom_slave #(.MEM_AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .scl_in(scl), .sda_in(sda),
    .sda_out(sda_out), .pl_valid(pl_valid), .pl_ready(pl_ready),
    .pl_addr(pl_addr), .pl_data(pl_data)
  );

  int   n_cmp = 0, n_bad = 0;
  bit   done = 1'b0;
  logic [7:0] exp_mem [DEPTH];

  // scoreboard: driver queues expected sda_out bits, monitor compares
  bit    expq[$];
  string tagq[$];
  bit    obs_req = 1'b0;

  always @(negedge clk) begin : monitor
    bit    e;
    string t;
    if (obs_req) begin
      e = expq.pop_front();
      t = tagq.pop_front();
      n_cmp++;
      if (sda_out !== e) begin
        n_bad++;
        $display("FAIL %s: sda_out=%0b expected %0b", t, sda_out, e);
      end
      obs_req = 1'b0;
    end
  end

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 29 + 7) ^ (a >> 3));
  endfunction

  task automatic check(input string t, input logic [15:0] act, input logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", t, act, exp);
    end
  endtask

  task automatic bus(input logic s, input logic d);
    @(negedge clk);
    #1;
    scl = s;
    sda = d;
    repeat (4) @(posedge clk);
  endtask

  task automatic expect_bit(input string t, input bit v);
    expq.push_back(v);
    tagq.push_back(t);
    obs_req = 1'b1;
    wait (obs_req == 1'b0);
  endtask

  task automatic start_c();
    bus(1'b0, 1'b1); bus(1'b1, 1'b1); bus(1'b1, 1'b0); bus(1'b0, 1'b0);
  endtask

  task automatic stop_c();
    bus(1'b0, 1'b0); bus(1'b1, 1'b0); bus(1'b1, 1'b1);
  endtask

  task automatic send_byte(input logic [7:0] v, input bit echo_chk);
    for (int i = 7; i >= 0; i--) begin
      bus(1'b0, v[i]); bus(1'b1, v[i]);
      if (echo_chk) expect_bit("R10 write echo", v[i]);
      bus(1'b0, v[i]);
    end
    bus(1'b0, 1'b1); bus(1'b1, 1'b1);
    expect_bit("R3 ack slot", 1'b0);
    bus(1'b0, 1'b1);
  endtask

  task automatic read_byte(input logic [7:0] e, input string t);
    for (int i = 7; i >= 0; i--) begin
      bus(1'b0, 1'b1); bus(1'b1, 1'b1);
      expect_bit(t, e[i]);
      bus(1'b0, 1'b1);
    end
    bus(1'b0, 1'b1); bus(1'b1, 1'b1);
    expect_bit("R3 ack slot", 1'b0);
    bus(1'b0, 1'b1);
  endtask

  task automatic leg_write(input logic [6:0] wa, input int n, input logic [7:0] seed);
    logic [6:0] idx = wa;
    start_c();
    send_byte({wa, 1'b0}, 1'b0);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d = seed ^ 8'(k * 8'h11);
      send_byte(d, 1'b1);
      exp_mem[idx] = d;
      idx = {idx[6:2], idx[1:0] + 2'd1};
    end
    stop_c();
  endtask

  task automatic leg_read(input logic [6:0] wa, input int n, input string t);
    logic [6:0] idx = wa;
    start_c();
    send_byte({wa, 1'b1}, 1'b0);
    for (int k = 0; k < n; k++) begin
      read_byte(exp_mem[idx], t);
      idx = idx + 7'd1;
    end
    stop_c();
  endtask

  function automatic logic [AW-1:0] ext_idx(input logic [7:0] ds, input logic [15:0] a, input bit two);
    return two ? a[AW-1:0] : {ds[3:1], a[7:0]};
  endfunction

  task automatic ext_write(input logic [7:0] ds, input logic [15:0] a, input bit two,
                           input int n, input logic [7:0] seed);
    logic [AW-1:0] idx = ext_idx(ds, a, two);
    start_c();
    send_byte({ds[7:1], 1'b0}, 1'b0);
    if (two) send_byte(a[15:8], 1'b0);
    send_byte(a[7:0], 1'b0);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d = seed + 8'(k * 8'h23);
      send_byte(d, 1'b1);
      exp_mem[idx] = d;
      idx = {idx[AW-1:4], idx[3:0] + 4'd1};
    end
    stop_c();
  endtask

  task automatic ext_read(input logic [7:0] ds, input logic [15:0] a, input bit two,
                          input int n, input string t);
    logic [AW-1:0] idx = ext_idx(ds, a, two);
    start_c();
    send_byte({ds[7:1], 1'b0}, 1'b0);
    if (two) send_byte(a[15:8], 1'b0);
    send_byte(a[7:0], 1'b0);
    start_c();
    send_byte({ds[7:1], 1'b1}, 1'b0);
    for (int k = 0; k < n; k++) begin
      read_byte(exp_mem[idx], t);
      idx = idx + AW'(1);
    end
    stop_c();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin : watchdog
    #(4 * 150000);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run still busy, expected completion");
      summary();
      $finish;
    end
  end

  initial begin : driver
    repeat (5) @(posedge clk);
    @(negedge clk);
    check("R1 reset echo", 16'(sda_out), 16'd1);
    rst_n = 1'b1;
    bus(1'b0, 1'b0);
    expect_bit("R1 idle echo low", 1'b0);
    bus(1'b0, 1'b1);
    expect_bit("R1 idle echo high", 1'b1);

    // R11 preload through the stream port
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk);
      #1;
      pl_valid = 1'b1;
      pl_addr  = AW'(a);
      pl_data  = pat(a);
      exp_mem[a] = pat(a);
      if (a == 0) check("R11 ready", 16'(pl_ready), 16'd1);
    end
    @(negedge clk);
    #1;
    pl_valid = 1'b0;

    mode = 2'd0;
    leg_read(7'h05, 1, "R11 preload readback");
    // R4 five bytes from word 0x12 wrap inside the page 0x10..0x13
    leg_write(7'h12, 5, 8'h3A);
    leg_read(7'h10, 6, "R4 legacy page wrap");
    leg_read(7'h7E, 3, "R5 legacy read wrap 128");

    mode = 2'd1;
    ext_write(8'hAA, 16'h003C, 1'b0, 1, 8'h5A);
    // R12 stray clocks while disarmed
    for (int k = 0; k < 9; k++) begin
      bus(1'b0, k[0]); bus(1'b1, k[0]); bus(1'b0, k[0]);
    end
    // R2 current-address read continues at 0x53D after the write
    start_c();
    send_byte(8'hAB, 1'b0);
    read_byte(exp_mem[11'h53D], "R2 address kept across start, R12 idle clocks ignored");
    read_byte(exp_mem[11'h53E], "R2 current read continues");
    stop_c();
    ext_read(8'hAA, 16'h003C, 1'b0, 1, "R6 select bits form address 10:8");

    mode = 2'd2;
    ext_write(8'hA0, 16'h07FB, 1'b1, 7, 8'hC1);
    ext_read(8'hA0, 16'h07FB, 1'b1, 5, "R7 two address bytes");
    ext_read(8'hA0, 16'h07F0, 1'b1, 2, "R8 page wrap 16");
    ext_read(8'hA0, 16'h07FE, 1'b1, 4, "R9 read crosses array top");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule